// File: doc/BRIEF.md
# Armed Single-Shot Stream Capture Buffer

This block sits at the end of a sample stream that cannot be paused and records one fixed-length snapshot of it into a dual-port memory. The write side runs on the converter clock. A host on a separate bus clock reads the result through a small memory-mapped slave. The stream input always reports ready. Words are stored only after the host has armed the block. Storing begins at address zero, advances by one on every valid word, and stops when the last location has been filled. From then on the stream is dropped until the host arms the block again.

The host starts a capture by writing a one to bit 0 of the control register. It then polls the status register until the done bit is set, and reads the snapshot out of a separate address window. A start request crosses into the converter domain as a toggle. The converter side returns a delayed acknowledge toggle, so the host never sees a stale done flag from the previous capture. The running word count crosses back in Gray code and can be watched while the capture is in progress.

Top module: `capbuf_ctrl`

## Requirements
- R1: `s_ready` is 1 in every cycle, whatever the state of the block.
- R2: After reset, status (offset 1) reads 0, count (offset 2) reads 0, and no word is stored until a start is issued.
- R3: Writing `bus_wdata`=1 to offset 0 (with `bus_addr[ADDR_W]`=0) requests a capture, and writing 0 there has no effect. From the first read after a start request until the capture ends, status bit 0 (busy) reads 1 and status bit 1 (done) reads 0.
- R4: While armed or filling, each cycle with `s_valid`=1 stores `s_data` at the next buffer location, starting at location 0. Cycles with `s_valid`=0 store nothing.
- R5: After 2**ADDR_W words have been stored, status reads 2 (done=1, busy=0), and later stream words leave the buffer unchanged.
- R6: A start request issued while a capture is filling is ignored: the capture goes on at the next location and is not restarted.
- R7: A start request issued while done is set clears done, sets the count to 0, and refills the buffer from location 0.
- R8: Count (offset 2) reads the number of words stored by the current capture. It reads 0 while a start request is not yet acknowledged.
- R9: A read with `bus_addr[ADDR_W]`=1 returns buffer location `bus_addr[ADDR_W-1:0]` zero-extended. It returns 0 when done is not set.
- R10: Every read returns its data on `bus_rdata` in the bus clock cycle after `bus_rd`. The control offset and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| adc_clk | input | 1 | Converter-domain clock |
| adc_rst_n | input | 1 | Asynchronous active-low reset, converter domain |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DATA_W | Stream word |
| s_ready | output | 1 | Always 1 |
| bus_clk | input | 1 | Host bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| bus_addr | input | ADDR_W+1 | Word address; the top bit selects the buffer window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 1 | Write value for the control bit |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | BUS_DW | Read data, one cycle after `bus_rd` |

## Verification
On every cycle, the assertions check that ready is held high and that the write address advances by exactly one after each stored word. They also check that the armed state always starts at location zero, that no word is stored once done, that a start request moves a done capture back to armed but leaves a filling capture alone, and that buffer reads return zero when done is not set. Several things only the bench scenarios can show: the stored contents match the exact order of valid words under different gap patterns, the count matches progress when the stream pauses part way, a second start during filling leaves the data contiguous, and re-arming replaces the whole snapshot. These all depend on comparing read-back data against sequences the bench generates.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_FILL  = 2'd2,
    CAP_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/capbuf_rstsync.sv
module capbuf_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/capbuf_bitsync.sv
module capbuf_bitsync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/capbuf_dpram.sv
module capbuf_dpram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/capbuf_fill.sv
module capbuf_fill
  import capbuf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int ACK_DLY = 2,
  localparam int CW     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic [CW-1:0]     cnt_gray,
  output logic              ack_tgl,
  output cap_state_e        state,
  output logic              start_evt
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [2:0]        req_s_q;
  cap_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CW-1:0]     gray_q;
  logic              busy_q, done_q;
  logic              tgl_q;
  logic              active;

  // start request synchronizer and edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_s_q <= 3'b000;
    else        req_s_q <= {req_s_q[1:0], req_tgl};
  end
  assign start_evt = req_s_q[2] ^ req_s_q[1];

  assign active = (state_q == CAP_ARMED) || (state_q == CAP_FILL);
  assign wr_en  = active && s_valid;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CAP_IDLE: begin
        if (start_evt) state_d = CAP_ARMED;
      end
      CAP_ARMED, CAP_FILL: begin
        if (s_valid) begin
          addr_d  = addr_q + 1'b1;
          cnt_d   = cnt_q + 1'b1;
          state_d = (addr_q == LAST) ? CAP_DONE : CAP_FILL;
        end
      end
      CAP_DONE: begin
        if (start_evt) begin
          state_d = CAP_ARMED;
          addr_d  = '0;
          cnt_d   = '0;
        end
      end
      default: state_d = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      gray_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      tgl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      gray_q  <= cnt_d ^ (cnt_d >> 1);
      busy_q  <= (state_d == CAP_ARMED) || (state_d == CAP_FILL);
      done_q  <= (state_d == CAP_DONE);
      if (start_evt) tgl_q <= ~tgl_q;
    end
  end

  // acknowledge lags the status flags so they settle first on the bus side
  logic [ACK_DLY-1:0] ack_sr_q;
  generate
    if (ACK_DLY == 1) begin : g_ack1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_sr_q <= '0;
        else        ack_sr_q <= tgl_q;
      end
    end else begin : g_ackn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_sr_q <= '0;
        else        ack_sr_q <= {ack_sr_q[ACK_DLY-2:0], tgl_q};
      end
    end
  endgenerate

  assign ack_tgl  = ack_sr_q[ACK_DLY-1];
  assign wr_addr  = addr_q;
  assign wr_data  = s_data;
  assign busy     = busy_q;
  assign done     = done_q;
  assign cnt_gray = gray_q;
  assign state    = state_q;
endmodule

// File: rtl/capbuf_regs.sv
module capbuf_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int BUS_DW = 32,
  localparam int CW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   bus_addr,
  input  logic              bus_wr,
  input  logic              bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              req_tgl,
  input  logic              ack_s,
  input  logic              busy_s,
  input  logic              done_s,
  input  logic [CW-1:0]     gray_s,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              done_view
);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(2);

  logic              req_q;
  logic              pending;
  logic              busy_v;
  logic              is_buf;
  logic [CW-1:0]     cnt_bin;
  logic [BUS_DW-1:0] reg_q;
  logic              bsel_q;
  logic              start_wr;

  assign is_buf   = bus_addr[ADDR_W];
  assign start_wr = bus_wr && !is_buf && (bus_addr[ADDR_W-1:0] == OFS_CTRL) && bus_wdata;
  assign pending  = req_q ^ ack_s;
  assign busy_v   = busy_s | pending;
  assign done_view = done_s & ~pending;

  always_comb begin
    for (int i = 0; i < CW; i++) cnt_bin[i] = ^(gray_s >> i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else if (start_wr) req_q <= ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      bsel_q <= 1'b0;
    end else if (bus_rd) begin
      bsel_q <= is_buf && done_view;
      if (is_buf) reg_q <= '0;
      else begin
        unique case (bus_addr[ADDR_W-1:0])
          OFS_STAT:  reg_q <= BUS_DW'({done_view, busy_v});
          OFS_COUNT: reg_q <= pending ? '0 : BUS_DW'(cnt_bin);
          default:   reg_q <= '0;
        endcase
      end
    end
  end

  assign ram_re    = bus_rd && is_buf;
  assign ram_raddr = bus_addr[ADDR_W-1:0];
  assign req_tgl   = req_q;
  assign bus_rdata = bsel_q ? BUS_DW'(ram_rdata) : reg_q;
endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
  import capbuf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int BUS_DW  = 32,
  parameter int ACK_DLY = 2
) (
  input  logic              adc_clk,
  input  logic              adc_rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic [ADDR_W:0]   bus_addr,
  input  logic              bus_wr,
  input  logic              bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_DW-1:0] bus_rdata
);
  localparam int CW = ADDR_W + 1;
  localparam int SW = CW + 3;

  logic              adc_rn, bus_rn;
  logic              req_tgl;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              busy_a, done_a, ack_a;
  logic [CW-1:0]     gray_a;
  cap_state_e        fill_state;
  logic              start_evt;
  logic [SW-1:0]     xs_q;
  logic              ram_re;
  logic [ADDR_W-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_rdata;
  logic              done_view;

  capbuf_rstsync u_rs_adc (.clk(adc_clk), .arst_n(adc_rst_n), .rst_n(adc_rn));
  capbuf_rstsync u_rs_bus (.clk(bus_clk), .arst_n(bus_rst_n), .rst_n(bus_rn));

  capbuf_fill #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACK_DLY(ACK_DLY)) u_fill (
    .clk(adc_clk), .rst_n(adc_rn), .req_tgl(req_tgl),
    .s_valid(s_valid), .s_data(s_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy_a), .done(done_a), .cnt_gray(gray_a), .ack_tgl(ack_a),
    .state(fill_state), .start_evt(start_evt)
  );

  capbuf_bitsync #(.W(SW)) u_xsync (
    .clk(bus_clk), .rst_n(bus_rn),
    .d({ack_a, busy_a, done_a, gray_a}), .q(xs_q)
  );

  capbuf_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(adc_clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .rclk(bus_clk), .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  capbuf_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUS_DW(BUS_DW)) u_regs (
    .clk(bus_clk), .rst_n(bus_rn),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .req_tgl(req_tgl),
    .ack_s(xs_q[SW-1]), .busy_s(xs_q[SW-2]), .done_s(xs_q[SW-3]),
    .gray_s(xs_q[CW-1:0]),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .done_view(done_view)
  );

  assign s_ready = 1'b1;
endmodule

// File: rtl/capbuf_ctrl_chk.sv
module capbuf_ctrl_chk
  import capbuf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BUS_DW = 32
) (
  input logic              adc_clk,
  input logic              adc_rst_n,
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              s_ready,
  input cap_state_e        state,
  input logic              start_evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              bus_rd,
  input logic              buf_sel,
  input logic              done_view,
  input logic [BUS_DW-1:0] bus_rdata
);
  p_ready_high_r1: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    s_ready);

  p_addr_step_r4: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    wr_en |=> wr_addr == $past(wr_addr) + 1'b1);

  p_armed_at_zero_r7: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    (state == CAP_ARMED) |-> (wr_addr == '0));

  p_silent_when_done_r5: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    (state == CAP_DONE) |-> !wr_en);

  p_fill_keeps_going_r6: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    (state == CAP_FILL && start_evt) |=> (state != CAP_ARMED));

  p_rearm_from_done_r7: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
    (state == CAP_DONE && start_evt) |=> (state == CAP_ARMED));

  p_hidden_until_done_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bus_rd && buf_sel && !done_view) |=> (bus_rdata == '0));
endmodule

bind capbuf_ctrl capbuf_ctrl_chk #(.ADDR_W(ADDR_W), .BUS_DW(BUS_DW)) u_chk (
  .adc_clk(adc_clk), .adc_rst_n(adc_rst_n), .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
  .s_ready(s_ready), .state(fill_state), .start_evt(start_evt),
  .wr_en(wr_en), .wr_addr(wr_addr), .bus_rd(bus_rd), .buf_sel(bus_addr[ADDR_W]),
  .done_view(done_view), .bus_rdata(bus_rdata)
);

// File: tb/tb_capbuf_ctrl.sv
module tb_capbuf_ctrl;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int BUS_DW = 32;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              adc_clk = 1'b0;
  logic              bus_clk = 1'b0;
  logic              adc_rst_n = 1'b0;
  logic              bus_rst_n = 1'b0;
  logic              s_valid = 1'b0;
  logic [DATA_W-1:0] s_data = '0;
  logic              s_ready;
  logic [ADDR_W:0]   bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_wdata = 1'b0;
  logic              bus_rd = 1'b0;
  logic [BUS_DW-1:0] bus_rdata;

  int errors = 0;
  int checks = 0;

  always #4 bus_clk = ~bus_clk;
  always #3 adc_clk = ~adc_clk;

  capbuf_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUS_DW(BUS_DW)) dut (.*);

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 11) & 8'hFF);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic v);
    @(negedge bus_clk);
    bus_addr = (ADDR_W+1)'(a); bus_wdata = v; bus_wr = 1'b1;
    @(negedge bus_clk);
    bus_wr = 1'b0; bus_wdata = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_addr = (ADDR_W+1)'(a); bus_rd = 1'b1;
    @(negedge bus_clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send(input int base, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge adc_clk);
      s_valid = 1'b1; s_data = pat(base + i);
      for (int g = 0; g < gap; g++) begin
        @(negedge adc_clk);
        s_valid = 1'b0; s_data = 8'hA5;
      end
    end
    @(negedge adc_clk);
    s_valid = 1'b0; s_data = 8'h5A;
  endtask

  task automatic settle();
    repeat (12) @(negedge bus_clk);
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 200; i++) begin
      bus_read(1, st);
      if (st[1]) break;
    end
  endtask

  task automatic check_buffer(input string tag, input int base);
    logic [31:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      bus_read(DEPTH + a, d);
      check(tag, d, 32'(pat(base + a)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge bus_clk);
    adc_rst_n = 1'b1; bus_rst_n = 1'b1;
    settle();

    // R2, R1, R9, R10 reset view
    bus_read(1, d); check("R2 status after reset", d, 0);
    bus_read(2, d); check("R2 count after reset", d, 0);
    bus_read(DEPTH + 3, d); check("R9 buffer before done", d, 0);
    bus_read(3, d); check("R10 unused offset", d, 0);
    bus_read(0, d); check("R10 control reads zero", d, 0);
    @(negedge adc_clk); check("R1 ready", 32'(s_ready), 1);

    // R3 writing zero does nothing; stream before arming is not stored
    bus_write(0, 1'b0);
    send(900, 4, 0);
    settle();
    bus_read(1, d); check("R3 zero write no effect", d, 0);
    bus_read(2, d); check("R2 nothing stored before start", d, 0);

    for (int gap = 0; gap < 4; gap++) begin
      int base;
      base = gap * 50;
      bus_write(0, 1'b1);
      bus_read(1, d); check("R3 busy right after start", d, 1);
      if (gap > 0) begin
        bus_read(2, d); check("R7 count cleared on restart", d, 0);
      end
      settle();
      send(base, 7, gap);
      settle();
      bus_read(2, d); check("R8 partial count", d, 7);
      bus_read(1, d); check("R4 busy while filling", d, 1);
      bus_read(DEPTH, d); check("R9 hidden while filling", d, 0);
      @(negedge adc_clk); check("R1 ready while filling", 32'(s_ready), 1);
      send(base + 7, DEPTH - 7 + 5, gap);
      settle();
      wait_done(d); check("R5 done status", d, 2);
      bus_read(2, d); check("R8 full count", d, DEPTH);
      check_buffer("R4 stored sequence", base);
      send(700, 10, 0);
      settle();
      check_buffer("R5 ignored after full", base);
      bus_read(1, d); check("R5 status stays done", d, 2);
    end

    // R6 start while filling is ignored
    bus_write(0, 1'b1);
    settle();
    send(300, 5, 1);
    bus_write(0, 1'b1);
    settle();
    bus_read(2, d); check("R6 count kept after second start", d, 5);
    send(305, DEPTH - 5 + 3, 1);
    settle();
    wait_done(d); check("R6 done", d, 2);
    check_buffer("R6 contiguous data", 300);

    // R7 restart replaces contents
    bus_write(0, 1'b1);
    settle();
    bus_read(1, d); check("R7 rearmed busy", d, 1);
    send(500, DEPTH, 2);
    settle();
    wait_done(d); check("R7 done again", d, 2);
    check_buffer("R7 new snapshot", 500);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule